// File: doc/BRIEF.md
# Sector Erase Window Status Generator

This block is the device side of a flash memory's status reporting for sector erase and buffered programming. The host issues sector erase command strobes, and each strobe carries a sector index. The block collects these sectors in a pending bitmap. Every accepted command opens a fixed acceptance window, or restarts it if it is already open. While the window is open the host may add more sectors.

When the window runs out with no new command, the block begins an erase of all queued sectors. The erase is modelled as a countdown whose length grows with the number of queued sectors. Once the erase phase has begun, further erase commands are dropped until it ends. Bit 3 of the status byte shows whether the erase phase is running, so software can tell whether its last command was accepted.

Bit 1 of the same byte reports that a buffered program was aborted. That flag remains set until a reset command clears it.

Top module: `erase_window_status`

## Requirements
- R1: During and after reset, `stat_byte` is 0, `busy` is 0 and `pend_map` is 0.
- R2: An in-range erase command that arrives while idle or while the window is open sets bit `cmd_sector` of `pend_map` from the next cycle. Status bit 3 reads 0 while the window is open.
- R3: The window stays open for WIN_CYC = CLK_MHZ*WIN_US cycles after the last accepted command. A command accepted in the final cycle of the window still restarts it.
- R4: When the window closes, status bit 3 reads 1 for (set bits in `pend_map`)*ERASE_CYC cycles. After that, bit 3 returns to 0, `pend_map` clears and the block goes idle. A sector that is queued twice is counted once.
- R5: An erase command that arrives during the erase phase has no effect: `pend_map` and the erase end time are unchanged.
- R6: A command whose sector index is NUM_SECT or higher is ignored in every state. It opens no window and sets no bit.
- R7: `busy` goes high in the cycle after the first accepted command and stays high until the erase phase completes.
- R8: Status bit 1 reads 0 until `wbuf_abort` is seen, then reads 1 from the next cycle.
- R9: Status bit 1 stays at 1 until `cmd_reset` arrives outside the erase phase. A reset during the erase phase is ignored. When `wbuf_abort` and `cmd_reset` arrive in the same cycle, the bit stays 1.
- R10: Status bits 7, 6, 5, 4, 2 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_erase_vld | input | 1 | One-cycle sector erase command strobe |
| cmd_sector | input | SEC_W | Sector index carried by the erase command |
| wbuf_abort | input | 1 | Write-buffer abort event |
| cmd_reset | input | 1 | Reset command that clears the abort flag |
| stat_byte | output | 8 | Status byte: bit 3 is the erase phase, bit 1 is the abort flag |
| busy | output | 1 | High while the window is open or the erase is running |
| pend_map | output | NUM_SECT | Bitmap of queued sectors |

## Verification
The bench builds the block with NUM_SECT=12, which leaves sector codes 12 to 15 reachable on the 4-bit index port, so out-of-range commands can be exercised. CLK_MHZ=1 with WIN_US=20 gives a 20-cycle window, and ERASE_CYC=6 makes each erase short. Together these let many window restarts, last-cycle arrivals, late commands and multi-sector erases occur within a few thousand cycles. Random phases alternate between dense and sparse command rates, so that windows are sometimes held open and sometimes allowed to expire.

// File: rtl/ews_pkg.sv
package ews_pkg;
   typedef enum logic [1:0] {
      EWS_IDLE   = 2'd0,
      EWS_WINDOW = 2'd1,
      EWS_ERASE  = 2'd2
   } ews_state_e;

   // bit positions decoded by host polling software
   localparam int unsigned ERASE_BIT = 3;
   localparam int unsigned ABORT_BIT = 1;
endpackage

// File: rtl/ews_downcount.sv
module ews_downcount #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec)
         cnt_q <= cnt_q - W'(1);
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/ews_sector_queue.sv
module ews_sector_queue #(
   parameter int NUM_SECT = 64,
   parameter int SEC_W    = 6,
   parameter int CNT_W    = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic [SEC_W-1:0]    set_idx,
   input  logic                clr,
   output logic                idx_ok,
   output logic [NUM_SECT-1:0] map,
   output logic [CNT_W-1:0]    count
);
   logic [CNT_W-1:0] part [NUM_SECT+1];

   // range check only exists when the index space is larger than the sector count
   generate
      if (NUM_SECT == (1 << SEC_W)) begin : g_full_range
         assign idx_ok = 1'b1;
      end else begin : g_part_range
         assign idx_ok = ({1'b0, set_idx} < (SEC_W+1)'(NUM_SECT));
      end
   endgenerate

   assign part[0] = '0;

   generate
      for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
         always_ff @(posedge clk) begin
            if (!rst_n || clr)
               map[i] <= 1'b0;
            else if (set_en && (set_idx == SEC_W'(i)))
               map[i] <= 1'b1;
         end
         assign part[i+1] = part[i] + CNT_W'(map[i]);
      end
   endgenerate

   assign count = part[NUM_SECT];
endmodule

// File: rtl/erase_window_status.sv
module erase_window_status
   import ews_pkg::*;
#(
   parameter int NUM_SECT  = 64,
   parameter int CLK_MHZ   = 200,
   parameter int WIN_US    = 50,
   parameter int ERASE_CYC = 100000,
   localparam int SEC_W    = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_erase_vld,
   input  logic [SEC_W-1:0]    cmd_sector,
   input  logic                wbuf_abort,
   input  logic                cmd_reset,
   output logic [7:0]          stat_byte,
   output logic                busy,
   output logic [NUM_SECT-1:0] pend_map
);
   localparam int WIN_CYC = CLK_MHZ * WIN_US;
   localparam int WIN_W   = $clog2(WIN_CYC + 1);
   localparam int ERS_MAX = NUM_SECT * ERASE_CYC;
   localparam int ERS_W   = $clog2(ERS_MAX + 1);
   localparam int CNT_W   = $clog2(NUM_SECT + 1);

   initial begin
      assert (NUM_SECT >= 1) else $error("NUM_SECT must be at least 1");
      assert (WIN_CYC >= 1) else $error("window must last at least one cycle");
      assert (ERASE_CYC >= 1) else $error("ERASE_CYC must be at least 1");
   end

   ews_state_e       st_q, st_d;
   logic             sec_ok, accept;
   logic             win_zero, win_load, win_dec;
   logic             ers_zero, ers_load, ers_dec;
   logic             q_clear;
   logic [CNT_W-1:0] sect_cnt;
   logic [ERS_W-1:0] ers_len;
   logic             abort_q;

   ews_sector_queue #(
      .NUM_SECT (NUM_SECT),
      .SEC_W    (SEC_W),
      .CNT_W    (CNT_W)
   ) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (accept),
      .set_idx (cmd_sector),
      .clr     (q_clear),
      .idx_ok  (sec_ok),
      .map     (pend_map),
      .count   (sect_cnt)
   );

   assign accept   = cmd_erase_vld && sec_ok && (st_q != EWS_ERASE);
   assign win_load = accept;
   assign win_dec  = (st_q == EWS_WINDOW) && !accept && !win_zero;
   assign ers_load = (st_q == EWS_WINDOW) && !accept && win_zero;
   assign ers_dec  = (st_q == EWS_ERASE) && !ers_zero;
   assign q_clear  = (st_q == EWS_ERASE) && ers_zero;
   assign ers_len  = ERS_W'(sect_cnt) * ERS_W'(ERASE_CYC) - ERS_W'(1);

   ews_downcount #(.W(WIN_W)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (win_load),
      .load_val (WIN_W'(WIN_CYC - 1)),
      .dec      (win_dec),
      .zero     (win_zero)
   );

   ews_downcount #(.W(ERS_W)) u_ers (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ers_load),
      .load_val (ers_len),
      .dec      (ers_dec),
      .zero     (ers_zero)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         EWS_IDLE:   if (accept) st_d = EWS_WINDOW;
         EWS_WINDOW: if (ers_load) st_d = EWS_ERASE;
         EWS_ERASE:  if (ers_zero) st_d = EWS_IDLE;
         default:    st_d = EWS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         st_q <= EWS_IDLE;
      else
         st_q <= st_d;
   end

   // abort event wins over a simultaneous reset command
   always_ff @(posedge clk) begin
      if (!rst_n)
         abort_q <= 1'b0;
      else if (wbuf_abort)
         abort_q <= 1'b1;
      else if (cmd_reset && (st_q != EWS_ERASE))
         abort_q <= 1'b0;
   end

   always_comb begin
      stat_byte            = '0;
      stat_byte[ERASE_BIT] = (st_q == EWS_ERASE);
      stat_byte[ABORT_BIT] = abort_q;
   end

   assign busy = (st_q != EWS_IDLE);
endmodule

// File: rtl/ews_checker.sv
module ews_checker #(
   parameter int NUM_SECT = 64,
   parameter int SEC_W    = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cmd_erase_vld,
   input logic [SEC_W-1:0]    cmd_sector,
   input logic                wbuf_abort,
   input logic                cmd_reset,
   input logic [7:0]          stat_byte,
   input logic                busy,
   input logic [NUM_SECT-1:0] pend_map
);
   logic in_range;
   assign in_range = ({1'b0, cmd_sector} < (SEC_W+1)'(NUM_SECT));

   assert_accept_sets_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_erase_vld && in_range && !stat_byte[3]) |=>
         (busy && !stat_byte[3] && pend_map[$past(cmd_sector)]));

   assert_erase_needs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stat_byte[3] |-> busy);

   assert_erase_end_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_byte[3]) |-> (!busy && (pend_map == '0)));

   assert_erase_map_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat_byte[3]) && stat_byte[3]) |-> (pend_map == $past(pend_map)));

   assert_range_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_erase_vld && !in_range && !busy) |=> !busy);

   assert_busy_has_queue_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (pend_map != '0));

   assert_abort_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wbuf_abort |=> stat_byte[1]);

   assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_reset && !wbuf_abort && !stat_byte[3]) |=> !stat_byte[1]);

   assert_spare_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_byte & 8'hF5) == 8'h00);
endmodule

bind erase_window_status ews_checker #(
   .NUM_SECT (NUM_SECT),
   .SEC_W    (SEC_W)
) u_ews_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_erase_vld (cmd_erase_vld),
   .cmd_sector    (cmd_sector),
   .wbuf_abort    (wbuf_abort),
   .cmd_reset     (cmd_reset),
   .stat_byte     (stat_byte),
   .busy          (busy),
   .pend_map      (pend_map)
);

// File: tb/erase_window_status_bench.sv
`timescale 1ns/1ps
module erase_window_status_bench;
   localparam int NS  = 12;
   localparam int MHZ = 1;
   localparam int WUS = 20;
   localparam int PER = 6;
   localparam int WIN = MHZ * WUS;
   localparam int SW  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_erase_vld = 1'b0;
   logic [SW-1:0] cmd_sector = '0;
   logic          wbuf_abort = 1'b0;
   logic          cmd_reset = 1'b0;
   logic [7:0]    stat_byte;
   logic          busy;
   logic [NS-1:0] pend_map;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   erase_window_status #(
      .NUM_SECT  (NS),
      .CLK_MHZ   (MHZ),
      .WIN_US    (WUS),
      .ERASE_CYC (PER)
   ) u_erase_window_status (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_erase_vld (cmd_erase_vld),
      .cmd_sector    (cmd_sector),
      .wbuf_abort    (wbuf_abort),
      .cmd_reset     (cmd_reset),
      .stat_byte     (stat_byte),
      .busy          (busy),
      .pend_map      (pend_map)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // reference model: 0 idle, 1 window, 2 erase
   int          m_st = 0;
   int          m_win = 0;
   int          m_ers = 0;
   logic [NS-1:0] m_map = '0;
   logic        m_abort = 1'b0;

   function automatic int erase_len(input logic [NS-1:0] m);
      return $countones(m) * PER;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_win = 0; m_ers = 0; m_map = '0; m_abort = 1'b0;
      end else begin
         bit acc;
         int pre;
         pre = m_st;
         acc = cmd_erase_vld && (int'(cmd_sector) < NS) && (pre != 2);
         if (wbuf_abort) m_abort = 1'b1;
         else if (cmd_reset && pre != 2) m_abort = 1'b0;
         case (pre)
            0: if (acc) begin m_map[cmd_sector] = 1'b1; m_win = WIN - 1; m_st = 1; end
            1: begin
               if (acc) begin m_map[cmd_sector] = 1'b1; m_win = WIN - 1; end
               else if (m_win == 0) begin m_st = 2; m_ers = erase_len(m_map) - 1; end
               else m_win--;
            end
            default: begin
               if (m_ers == 0) begin m_st = 0; m_map = '0; end
               else m_ers--;
            end
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 erase bit", 32'(stat_byte[3]), 32'(m_st == 2));
         chk("R8 abort bit", 32'(stat_byte[1]), 32'(m_abort));
         chk("R7 busy", 32'(busy), 32'(m_st != 0));
         chk("R2 map", 32'(pend_map), 32'(m_map));
         chk("R10 spare bits", 32'(stat_byte & 8'hF5), 32'h0);
      end
   end

   task automatic step(input logic c, input int s, input logic a, input logic r);
      cmd_erase_vld = c; cmd_sector = SW'(s); wbuf_abort = a; cmd_reset = r;
      @(posedge clk); @(negedge clk);
      cmd_erase_vld = 1'b0; wbuf_abort = 1'b0; cmd_reset = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 1'b0);
   endtask

   task automatic finish_run();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk("R1 reset status", 32'(stat_byte), 32'h0);
      chk("R1 reset busy", 32'(busy), 32'h0);
      chk("R1 reset map", 32'(pend_map), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset status", 32'(stat_byte), 32'h0);

      // single sector: window length and erase length
      step(1'b1, 5, 1'b0, 1'b0);
      chk("R7 busy after command", 32'(busy), 32'h1);
      chk("R2 bit set", 32'(pend_map), 32'h20);
      chk("R2 window reads 0", 32'(stat_byte[3]), 32'h0);
      idle(WIN - 1);
      chk("R3 last window cycle", 32'(stat_byte[3]), 32'h0);
      idle(1);
      chk("R4 erase begins", 32'(stat_byte[3]), 32'h1);
      idle(PER - 1);
      chk("R4 erase still running", 32'(stat_byte[3]), 32'h1);
      idle(1);
      chk("R4 erase done", 32'(stat_byte[3]), 32'h0);
      chk("R7 idle after erase", 32'(busy), 32'h0);
      chk("R4 map cleared", 32'(pend_map), 32'h0);

      // restart mid-window, two sectors
      step(1'b1, 2, 1'b0, 1'b0);
      idle(WIN - 3);
      step(1'b1, 7, 1'b0, 1'b0);
      chk("R2 two sectors", 32'(pend_map), 32'h84);
      idle(WIN - 1);
      chk("R3 restarted window open", 32'(stat_byte[3]), 32'h0);
      idle(1);
      chk("R3 restarted window closed", 32'(stat_byte[3]), 32'h1);
      idle(2 * PER - 1);
      chk("R4 two-sector erase running", 32'(stat_byte[3]), 32'h1);
      idle(1);
      chk("R4 two-sector erase done", 32'(busy), 32'h0);

      // command in final window cycle, then late command during erase
      step(1'b1, 1, 1'b0, 1'b0);
      idle(WIN - 1);
      step(1'b1, 4, 1'b0, 1'b0);
      chk("R3 last-cycle command accepted", 32'(pend_map), 32'h12);
      chk("R3 window still open", 32'(stat_byte[3]), 32'h0);
      idle(WIN - 1);
      chk("R3 window open after last-cycle restart", 32'(stat_byte[3]), 32'h0);
      idle(1);
      chk("R4 erase after restart", 32'(stat_byte[3]), 32'h1);
      step(1'b1, 9, 1'b0, 1'b0);
      chk("R5 late command dropped", 32'(pend_map), 32'h12);
      idle(2 * PER - 2);
      chk("R5 erase end unchanged", 32'(stat_byte[3]), 32'h1);
      idle(1);
      chk("R5 erase ends on time", 32'(stat_byte[3]), 32'h0);
      chk("R5 no leftover sector", 32'(pend_map), 32'h0);

      // out-of-range sectors
      step(1'b1, 13, 1'b0, 1'b0);
      chk("R6 idle stays idle", 32'(busy), 32'h0);
      chk("R6 no bit set", 32'(pend_map), 32'h0);
      step(1'b1, 3, 1'b0, 1'b0);
      step(1'b1, 14, 1'b0, 1'b0);
      chk("R6 dropped in window", 32'(pend_map), 32'h8);
      idle(WIN - 2);
      chk("R6 no restart", 32'(stat_byte[3]), 32'h0);
      idle(1);
      chk("R6 window expired on time", 32'(stat_byte[3]), 32'h1);
      idle(PER);
      chk("R6 erase done", 32'(busy), 32'h0);

      // duplicate sector counted once
      step(1'b1, 6, 1'b0, 1'b0);
      step(1'b1, 6, 1'b0, 1'b0);
      idle(WIN - 1);
      chk("R3 duplicate restarts window", 32'(stat_byte[3]), 32'h0);
      idle(1);
      idle(PER - 1);
      chk("R4 duplicate erase running", 32'(stat_byte[3]), 32'h1);
      idle(1);
      chk("R4 duplicate counted once", 32'(stat_byte[3]), 32'h0);

      // abort flag
      chk("R8 abort clear initially", 32'(stat_byte[1]), 32'h0);
      step(1'b0, 0, 1'b1, 1'b0);
      chk("R8 abort set", 32'(stat_byte[1]), 32'h1);
      idle(5);
      chk("R9 abort held", 32'(stat_byte[1]), 32'h1);
      step(1'b0, 0, 1'b0, 1'b1);
      chk("R9 reset clears", 32'(stat_byte[1]), 32'h0);
      step(1'b0, 0, 1'b1, 1'b0);
      step(1'b1, 0, 1'b0, 1'b0);
      idle(WIN);
      chk("R4 erase for abort test", 32'(stat_byte[3]), 32'h1);
      step(1'b0, 0, 1'b0, 1'b1);
      chk("R9 reset ignored in erase", 32'(stat_byte[1]), 32'h1);
      idle(PER - 1);
      chk("R7 idle again", 32'(busy), 32'h0);
      step(1'b0, 0, 1'b0, 1'b1);
      chk("R9 reset clears after erase", 32'(stat_byte[1]), 32'h0);
      step(1'b0, 0, 1'b1, 1'b1);
      chk("R9 abort wins over reset", 32'(stat_byte[1]), 32'h1);
      step(1'b0, 0, 1'b0, 1'b1);
      chk("R9 final clear", 32'(stat_byte[1]), 32'h0);

      // random phases, dense and sparse commands
      for (int seg = 0; seg < 6; seg++) begin
         int div;
         div = (seg % 2 == 1) ? 6 : 60;
         for (int c = 0; c < 500; c++) begin
            step(($urandom % div) == 0, int'($urandom % 16),
                 ($urandom % 64) == 0, ($urandom % 32) == 0);
         end
      end

      finish_run();
   end
endmodule